// File: doc/BRIEF.md
# Burst Address Order Generator

This block produces the word address for each data phase of a memory-space burst. It is loaded with the starting byte address of a transaction. The two lowest bits of that address carry an ordering code and are not part of the word address. The block then presents the first word address. Each time the bus side reports a completed data phase, it steps to the next address in the requested order. Three orders are supported: plain linear increment, cache-line toggle and cache-line wrap. Toggle and wrap are critical-word-first orders: they visit the rest of the current cache line first and then continue from the same offset in the following line. The line size comes from a configuration input.

Some combinations cannot be burst. These are the reserved ordering code, a line-size setting the block does not support, and a non-linear order requested in I/O or configuration space. For any of them the block enters a single-word state. It presents only the first word and flags that the target has to disconnect after that transfer. A control state machine with three states, `ST_IDLE`, `ST_BURST` and `ST_SINGLE`, governs loading and stepping.

The state transitions are:
- Start from any state: goes to `ST_SINGLE` when the request cannot be burst, otherwise to `ST_BURST`.
- Advance in `ST_BURST`: stays in `ST_BURST` and steps the counter.
- Advance in `ST_SINGLE`: goes to `ST_IDLE`.
- Advance in `ST_IDLE`: ignored.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset, `active_o` and `single_o` are 0, `order_o` is 00 and `addr_o` is 0.
- R2: One cycle after `start_i`, `addr_o` equals `start_addr_i` with bits 1:0 cleared and `active_o` is 1. Bits 1:0 of `addr_o` are always 0.
- R3: When neither `start_i` nor `advance_i` is asserted, `addr_o`, `active_o` and `single_o` keep their values.
- R4: Ordering code 00 (`start_addr_i[1:0]`) is linear. Each advance adds 4 to `addr_o`, crossing line boundaries freely. For example, a start at 0x0C gives 0x0C, 0x10, 0x14, 0x18, 0x1C.
- R5: Ordering code 01 is toggle. After k advances, the offset within the line is the starting word offset XOR k (low bits), and the line is the starting line plus k divided by the line length. For a 4-word line starting at 0x0C this gives 0x0C, 0x08, 0x04, 0x00, 0x1C, 0x18.
- R6: Ordering code 10 is wrap. The offset within the line is (starting offset + k) modulo the line length, and the line advances as in R5. For a 4-word line starting at 0x0C this gives 0x0C, 0x00, 0x04, 0x08, 0x1C, 0x10.
- R7: When the starting word offset within the line is zero, codes 00, 01 and 10 produce the same address sequence.
- R8: `line_sel_i` selects the line length: 00 is 4 words, 01 is 8 words, 10 is 16 words. Value 11 is unsupported and puts the burst in the single-word state for every order.
- R9: Ordering code 11 is reserved and puts the burst in the single-word state.
- R10: With `mem_space_i` = 0, code 00 runs a normal linear burst, while codes 01 and 10 put the burst in the single-word state.
- R11: In the single-word state, `single_o` and `active_o` are 1 and `order_o` is 00. The first advance drops `active_o` and `single_o` to 0 while `addr_o` keeps the first word.
- R12: `order_o` reports the effective order of the running burst (the code for a burst, 00 for single-word). `start_i` takes priority over `advance_i` in the same cycle and restarts the sequence from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load a new burst from `start_addr_i` |
| start_addr_i | input | ADDR_W | Starting byte address; bits 1:0 carry the ordering code |
| mem_space_i | input | 1 | 1 for memory space, 0 for I/O or configuration space |
| line_sel_i | input | 2 | Cache-line length select |
| advance_i | input | 1 | A data phase completed; step to the next word |
| addr_o | output | ADDR_W | Current word address, bits 1:0 zero |
| active_o | output | 1 | A burst address is being presented |
| single_o | output | 1 | Target must disconnect after the first word |
| order_o | output | 2 | Effective order of the running burst |

## Verification
The properties assume that `start_i`, `advance_i` and the configuration inputs are synchronous and free of X after reset. They also assume that `start_addr_i`, `mem_space_i` and `line_sel_i` only matter in the cycle `start_i` is high. The bench drives every input on the falling edge, keeps start strobes one cycle long, and holds the configuration inputs steady around each strobe. It also asserts `advance_i` in idle and single-word states, so that the ignore and end-of-burst paths are exercised through the same inputs the properties watch.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ORD_LINEAR = 2'b00,
        ORD_TOGGLE = 2'b01,
        ORD_WRAP   = 2'b10,
        ORD_RSVD   = 2'b11
    } order_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_BURST  = 2'b01,
        ST_SINGLE = 2'b10
    } state_e;

endpackage

// File: rtl/burst_order_check.sv
module burst_order_check
    import burst_seq_pkg::*;
#(
    parameter int N_SIZES = 3,
    parameter int SEL_W   = 2
) (
    input  logic [1:0]       code_i,
    input  logic [SEL_W-1:0] line_sel_i,
    input  logic             mem_space_i,
    output logic             single_o,
    output order_e           order_o
);

    logic size_ok;
    logic rsvd;
    logic space_bad;

    always_comb begin
        size_ok   = (int'(line_sel_i) < N_SIZES);
        rsvd      = (order_e'(code_i) == ORD_RSVD);
        space_bad = !mem_space_i && (order_e'(code_i) != ORD_LINEAR);
        single_o  = rsvd || !size_ok || space_bad;
        order_o   = single_o ? ORD_LINEAR : order_e'(code_i);
    end

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
    import burst_seq_pkg::*;
#(
    parameter int WA_W    = 30,
    parameter int CNT_W   = 16,
    parameter int N_SIZES = 3,
    parameter int MIN_LB  = 2,
    parameter int SEL_W   = 2
) (
    input  logic [WA_W-1:0]  w0_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  order_e           order_i,
    input  logic [SEL_W-1:0] line_sel_i,
    output logic [WA_W-1:0]  word_o
);

    logic [WA_W-1:0] k_ext;
    logic [WA_W-1:0] lin_word;
    logic [WA_W-1:0] cand [N_SIZES];

    always_comb begin
        k_ext    = WA_W'(cnt_i);
        lin_word = w0_i + k_ext;
    end

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int LB = MIN_LB + g;
        logic [WA_W-1:0] line_n;
        logic [LB-1:0]   off0;
        logic [LB-1:0]   kk;
        logic [LB-1:0]   off;

        always_comb begin
            line_n = (w0_i >> LB) + (k_ext >> LB);
            off0   = w0_i[LB-1:0];
            kk     = k_ext[LB-1:0];
            unique case (order_i)
                ORD_TOGGLE: off = off0 ^ kk;
                ORD_WRAP:   off = off0 + kk;
                default:    off = off0;
            endcase
            cand[g] = (line_n << LB) | WA_W'(off);
        end
    end

    always_comb begin
        word_o = lin_word;
        if (order_i == ORD_TOGGLE || order_i == ORD_WRAP) begin
            for (int g = 0; g < N_SIZES; g++) begin
                if (int'(line_sel_i) == g) word_o = cand[g];
            end
        end
    end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int WA_W  = 30,
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             advance_i,
    input  logic [WA_W-1:0]  start_word_i,
    input  logic [SEL_W-1:0] line_sel_i,
    input  logic             single_req_i,
    input  order_e           order_req_i,
    output logic [WA_W-1:0]  w0_o,
    output logic [CNT_W-1:0] cnt_o,
    output order_e           order_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             active_o,
    output logic             single_o
);

    state_e           state_q, state_d;
    logic [WA_W-1:0]  w0_q;
    logic [CNT_W-1:0] cnt_q;
    order_e           ord_q;
    logic [SEL_W-1:0] sel_q;
    logic             load;
    logic             bump;

    // next-state decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        bump    = 1'b0;
        if (start_i) begin
            load    = 1'b1;
            state_d = single_req_i ? ST_SINGLE : ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_BURST:  bump = advance_i;
                ST_SINGLE: if (advance_i) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register and burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            w0_q    <= '0;
            cnt_q   <= '0;
            ord_q   <= ORD_LINEAR;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                w0_q  <= start_word_i;
                cnt_q <= '0;
                ord_q <= order_req_i;
                sel_q <= line_sel_i;
            end else if (bump) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        w0_o     = w0_q;
        cnt_o    = cnt_q;
        order_o  = ord_q;
        sel_o    = sel_q;
        active_o = (state_q != ST_IDLE);
        single_o = (state_q == ST_SINGLE);
    end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int N_SIZES = 3,
    parameter int MIN_LB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              mem_space_i,
    input  logic [1:0]        line_sel_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              active_o,
    output logic              single_o,
    output logic [1:0]        order_o
);

    localparam int WA_W  = ADDR_W - 2;
    localparam int SEL_W = 2;

    logic             single_req;
    order_e           order_req;
    logic [WA_W-1:0]  w0;
    logic [CNT_W-1:0] cnt;
    order_e           ord_run;
    logic [SEL_W-1:0] sel_run;
    logic [WA_W-1:0]  word;

    burst_order_check #(
        .N_SIZES (N_SIZES),
        .SEL_W   (SEL_W)
    ) chk_u (
        .code_i      (start_addr_i[1:0]),
        .line_sel_i  (line_sel_i),
        .mem_space_i (mem_space_i),
        .single_o    (single_req),
        .order_o     (order_req)
    );

    burst_seq_ctrl #(
        .WA_W  (WA_W),
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) ctrl_u (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .advance_i    (advance_i),
        .start_word_i (start_addr_i[ADDR_W-1:2]),
        .line_sel_i   (line_sel_i),
        .single_req_i (single_req),
        .order_req_i  (order_req),
        .w0_o         (w0),
        .cnt_o        (cnt),
        .order_o      (ord_run),
        .sel_o        (sel_run),
        .active_o     (active_o),
        .single_o     (single_o)
    );

    burst_addr_calc #(
        .WA_W    (WA_W),
        .CNT_W   (CNT_W),
        .N_SIZES (N_SIZES),
        .MIN_LB  (MIN_LB),
        .SEL_W   (SEL_W)
    ) calc_u (
        .w0_i       (w0),
        .cnt_i      (cnt),
        .order_i    (ord_run),
        .line_sel_i (sel_run),
        .word_o     (word)
    );

    always_comb begin
        addr_o  = {word, 2'b00};
        order_o = ord_run;
    end

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              mem_space_i,
    input logic [1:0]        line_sel_i,
    input logic              advance_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              active_o,
    input logic              single_o,
    input logic [1:0]        order_o
);

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[1:0] == 2'b00);

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_o == {$past(start_addr_i[ADDR_W-1:2]), 2'b00}) && active_o);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !advance_i) |=> $stable(addr_o) && $stable(active_o) && $stable(single_o));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !single_o && order_o == 2'b00 && advance_i && !start_i)
        |=> addr_o == $past(addr_o) + ADDR_W'(4));

    assert_size_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && line_sel_i == 2'b11) |=> single_o);

    assert_rsvd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && start_addr_i[1:0] == 2'b11) |=> single_o && order_o == 2'b00);

    assert_space_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mem_space_i && start_addr_i[1:0] != 2'b00) |=> single_o);

    assert_space_linear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mem_space_i && start_addr_i[1:0] == 2'b00 && line_sel_i != 2'b11)
        |=> !single_o && active_o);

    assert_single_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (single_o && advance_i && !start_i) |=> !active_o && !single_o && $stable(addr_o));

    assert_single_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        single_o |-> active_o && order_o == 2'b00);

endmodule

bind burst_seq_gen burst_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .mem_space_i  (mem_space_i),
    .line_sel_i   (line_sel_i),
    .advance_i    (advance_i),
    .addr_o       (addr_o),
    .active_o     (active_o),
    .single_o     (single_o),
    .order_o      (order_o)
);

// File: tb/burst_seq_gen_tb.sv
module burst_seq_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        mem_space_i = 1'b1;
    logic [1:0]  line_sel_i = 2'b00;
    logic        advance_i = 1'b0;
    logic [31:0] addr_o;
    logic        active_o;
    logic        single_o;
    logic [1:0]  order_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_seq_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .mem_space_i  (mem_space_i),
        .line_sel_i   (line_sel_i),
        .advance_i    (advance_i),
        .addr_o       (addr_o),
        .active_o     (active_o),
        .single_o     (single_o),
        .order_o      (order_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Independent sequence model from the requirement text.
    function automatic logic [31:0] model(input logic [31:0] sa, input int lb, input int k);
        int unsigned w0, mask, line, off;
        w0   = sa >> 2;
        mask = (1 << lb) - 1;
        if (sa[1:0] == 2'b00) return (w0 + k) << 2;
        line = (w0 >> lb) + (k >> lb);
        if (sa[1:0] == 2'b01) off = (w0 & mask) ^ (k & mask);
        else                  off = ((w0 & mask) + k) & mask;
        return ((line << lb) | off) << 2;
    endfunction

    task automatic do_start(input logic [31:0] sa, input logic [1:0] sel, input logic mem);
        @(negedge clk);
        start_addr_i = sa; line_sel_i = sel; mem_space_i = mem; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_adv();
        @(negedge clk);
        advance_i = 1'b1;
        @(negedge clk);
        advance_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 addr", addr_o, 32'h0);
        check("R1 active", {31'b0, active_o}, 32'h0);
        check("R1 single", {31'b0, single_o}, 32'h0);
        check("R1 order", {30'b0, order_o}, 32'h0);
    endtask

    task automatic t_linear();
        logic [31:0] exp [5] = '{32'h0C, 32'h10, 32'h14, 32'h18, 32'h1C};
        do_start(32'h0000_000C, 2'b00, 1'b1);
        check("R2 active", {31'b0, active_o}, 32'h1);
        for (int i = 0; i < 5; i++) begin
            if (i > 0) do_adv();
            check("R4 linear", addr_o, exp[i]);
        end
        check("R12 order linear", {30'b0, order_o}, 32'h0);
    endtask

    task automatic t_toggle();
        logic [31:0] exp [6] = '{32'h0C, 32'h08, 32'h04, 32'h00, 32'h1C, 32'h18};
        do_start(32'h0000_000D, 2'b00, 1'b1);
        check("R12 order toggle", {30'b0, order_o}, 32'h1);
        for (int i = 0; i < 6; i++) begin
            if (i > 0) do_adv();
            check("R5 toggle", addr_o, exp[i]);
        end
    endtask

    task automatic t_wrap();
        logic [31:0] exp [6] = '{32'h0C, 32'h00, 32'h04, 32'h08, 32'h1C, 32'h10};
        do_start(32'h0000_000E, 2'b00, 1'b1);
        check("R12 order wrap", {30'b0, order_o}, 32'h2);
        for (int i = 0; i < 6; i++) begin
            if (i > 0) do_adv();
            check("R6 wrap", addr_o, exp[i]);
        end
    endtask

    task automatic t_sizes();
        logic [31:0] sa;
        sa = 32'h0000_1016;
        do_start(sa, 2'b01, 1'b1);
        for (int i = 0; i < 10; i++) begin
            if (i > 0) do_adv();
            check("R8 wrap 8 words", addr_o, model(sa, 3, i));
        end
        sa = 32'h0000_203D;
        do_start(sa, 2'b10, 1'b1);
        for (int i = 0; i < 20; i++) begin
            if (i > 0) do_adv();
            check("R8 toggle 16 words", addr_o, model(sa, 4, i));
        end
        sa = 32'h0000_0016;
        do_start(sa, 2'b11, 1'b1);
        check("R8 unsupported size single", {31'b0, single_o}, 32'h1);
        check("R8 unsupported size addr", addr_o, 32'h14);
    endtask

    task automatic t_zero_offset();
        for (int c = 0; c < 3; c++) begin
            do_start(32'h0000_0040 | c, 2'b00, 1'b1);
            for (int i = 0; i < 6; i++) begin
                if (i > 0) do_adv();
                check("R7 zero offset", addr_o, 32'h40 + 4 * i);
            end
        end
    endtask

    task automatic t_reserved();
        do_start(32'h0000_000F, 2'b00, 1'b1);
        check("R9 single", {31'b0, single_o}, 32'h1);
        check("R9 addr", addr_o, 32'h0C);
        check("R11 order", {30'b0, order_o}, 32'h0);
        do_adv();
        check("R11 active ends", {31'b0, active_o}, 32'h0);
        check("R11 single ends", {31'b0, single_o}, 32'h0);
        check("R11 addr kept", addr_o, 32'h0C);
        do_adv();
        check("R11 idle advance ignored", addr_o, 32'h0C);
    endtask

    task automatic t_nonmem();
        do_start(32'h0000_0031, 2'b00, 1'b0);
        check("R10 toggle io single", {31'b0, single_o}, 32'h1);
        do_start(32'h0000_0032, 2'b01, 1'b0);
        check("R10 wrap io single", {31'b0, single_o}, 32'h1);
        do_start(32'h0000_0030, 2'b00, 1'b0);
        check("R10 linear io burst", {31'b0, single_o}, 32'h0);
        do_adv();
        do_adv();
        check("R10 linear io step", addr_o, 32'h38);
    endtask

    task automatic t_hold();
        do_start(32'h0000_0104, 2'b00, 1'b1);
        do_adv();
        repeat (4) @(negedge clk);
        check("R3 hold addr", addr_o, 32'h108);
        check("R3 hold active", {31'b0, active_o}, 32'h1);
    endtask

    task automatic t_priority();
        do_start(32'h0000_0200, 2'b00, 1'b1);
        do_adv();
        @(negedge clk);
        start_addr_i = 32'h0000_0502; line_sel_i = 2'b00; mem_space_i = 1'b1;
        start_i = 1'b1; advance_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; advance_i = 1'b0;
        check("R12 start wins", addr_o, 32'h500);
        do_adv();
        check("R12 restart wrap", addr_o, 32'h504);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_toggle();
        t_wrap();
        t_sizes();
        t_zero_offset();
        t_reserved();
        t_nonmem();
        t_hold();
        t_priority();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule